// File: doc/BRIEF.md
# Multichannel Pulse-Width Modulator with Pair Concatenation

The block drives eight pulse-width modulated outputs from a single bus clock. Each channel owns an 8-bit up-counter, a period value and a duty value. Each channel also has a polarity bit, an enable bit and a clock-select bit. Two prescaled tick streams, A and B, are produced from the bus clock by power-of-two division. A second scaling stage on each side turns these into the slower streams SA and SB. Through its select bit, each channel counts on either the plain or the scaled stream of its side.

Any even/odd channel pair can be joined into one 16-bit modulator. In that mode the even channel's registers hold the upper byte and the odd channel's registers hold the lower byte. The odd channel's enable, polarity and clock select are used, and the waveform appears on the odd output. Period and duty writes go to holding registers. The running waveform picks them up only at a period boundary or when the channel is enabled, so a write made in mid-period never produces a runt pulse.

Software programs the block through a write-only port: one address and one data byte per cycle.

Top module: `pwm_multi`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`. The address map is as follows:
  - 0x00 holds the enable mask, with bit i for channel i.
  - 0x01 holds the polarity mask.
  - 0x02 holds the clock-select mask.
  - 0x03 holds the pair-join mask, with bit k joining channels 2k and 2k+1.
  - 0x04 holds the prescale fields: A in bits 2:0 and B in bits 6:4.
  - 0x05 holds the scale value for A. 0x06 holds the scale value for B.
  - 0x10+i holds the period of channel i. 0x18+i holds the duty of channel i.
- R2: After reset, all registers are zero and every output is low.
- R3: The A stream ticks once every 2^n bus cycles, where n is the A prescale field. The B stream does the same with its own field.
- R4: SA ticks once every 2*S ticks of A, where S is the A scale value and S = 0 counts as 256. SB is derived from B in the same way.
- R5: Channels 0, 1, 4 and 5 take their clock from the A side; channels 2, 3, 6 and 7 take it from the B side. A select bit of 1 picks the scaled stream and 0 picks the plain stream. The plain B stream is not affected by the A prescale setting.
- R6: With polarity 1, an enabled channel counts 0 to period-1 on its clock. Its output is high while count < duty and low for the rest of the period.
- R7: With polarity 0, the waveform of R6 is inverted.
- R8: If duty ≥ period, the output holds the active level for the whole period. If duty = 0, it holds the inactive level.
- R9: A disabled channel drives its output low and holds its counter at 0. Enabling it restarts the count from 0.
- R10: A period or duty write takes effect only when the counter wraps or the channel is enabled. Until then, the current period's waveform is unchanged.
- R11: With pair k joined, channel 2k+1 produces a 16-bit waveform. Its period is {period(2k), period(2k+1)} and its duty is {duty(2k), duty(2k+1)}. It uses the odd channel's enable, polarity and clock. The even output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 8 | Channel waveforms, bit i for channel i |

## Verification
The two functions that can fall in the same cycle are a software write to a duty register and the running counter's progress through the current period. Both act on what the comparator uses. The bench synchronises to the start of a period on one channel and lets the count pass the old duty. It then writes a larger duty, so that an unbuffered design would raise the output at once. The bench judges the output at the very next sample, where it must stay low. It then measures whole later periods to confirm that the new duty has arrived at the boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W = 6;
    localparam int PRE_W  = 3;

    localparam logic [ADDR_W-1:0] ADR_EN  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_POL = 6'h01;
    localparam logic [ADDR_W-1:0] ADR_SEL = 6'h02;
    localparam logic [ADDR_W-1:0] ADR_CAT = 6'h03;
    localparam logic [ADDR_W-1:0] ADR_PRE = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_SCA = 6'h05;
    localparam logic [ADDR_W-1:0] ADR_SCB = 6'h06;

    // group codes in the upper address bits for per-channel arrays
    localparam int GRP_PER  = 2;
    localparam int GRP_DUTY = 3;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic [NCH-1:0]           en_o,
    output logic [NCH-1:0]           pol_o,
    output logic [NCH-1:0]           sel_o,
    output logic [NCH/2-1:0]         cat_o,
    output logic [PRE_W-1:0]         pre_a_o,
    output logic [PRE_W-1:0]         pre_b_o,
    output logic [CW-1:0]            scl_a_o,
    output logic [CW-1:0]            scl_b_o,
    output logic [NCH-1:0][CW-1:0]   per_o,
    output logic [NCH-1:0][CW-1:0]   duty_o
);
    localparam int NP = NCH / 2;
    localparam int IW = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0]         en;
        logic [NCH-1:0]         pol;
        logic [NCH-1:0]         sel;
        logic [NP-1:0]          cat;
        logic [PRE_W-1:0]       pa;
        logic [PRE_W-1:0]       pb;
        logic [CW-1:0]          sa;
        logic [CW-1:0]          sb;
        logic [NCH-1:0][CW-1:0] per;
        logic [NCH-1:0][CW-1:0] duty;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [ADDR_W-1:0] grp;

    always_comb begin
        rf_d = rf_q;
        grp  = wr_addr >> IW;
        if (wr_en) begin
            case (wr_addr)
                ADR_EN:  rf_d.en  = wr_data[NCH-1:0];
                ADR_POL: rf_d.pol = wr_data[NCH-1:0];
                ADR_SEL: rf_d.sel = wr_data[NCH-1:0];
                ADR_CAT: rf_d.cat = wr_data[NP-1:0];
                ADR_PRE: begin
                    rf_d.pa = wr_data[PRE_W-1:0];
                    rf_d.pb = wr_data[4+PRE_W-1:4];
                end
                ADR_SCA: rf_d.sa = wr_data;
                ADR_SCB: rf_d.sb = wr_data;
                default: begin
                    if (grp == ADDR_W'(GRP_PER))
                        rf_d.per[wr_addr[IW-1:0]] = wr_data;
                    else if (grp == ADDR_W'(GRP_DUTY))
                        rf_d.duty[wr_addr[IW-1:0]] = wr_data;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign en_o    = rf_q.en;
    assign pol_o   = rf_q.pol;
    assign sel_o   = rf_q.sel;
    assign cat_o   = rf_q.cat;
    assign pre_a_o = rf_q.pa;
    assign pre_b_o = rf_q.pb;
    assign scl_a_o = rf_q.sa;
    assign scl_b_o = rf_q.sb;
    assign per_o   = rf_q.per;
    assign duty_o  = rf_q.duty;
endmodule

// File: rtl/pwm_scaler.sv
module pwm_scaler
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre,
    input  logic [CW-1:0]    scl,
    output logic             tick_o,
    output logic             stick_o
);
    localparam int PCW = (1 << PRE_W) - 1;
    localparam int SCW = CW + 1;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [SCW-1:0] sc;
    } sc_t;

    sc_t s_d, s_q;
    logic [PCW-1:0] mask;
    logic [SCW-1:0] lim;

    always_comb begin
        mask    = PCW'((32'd1 << pre) - 32'd1);
        tick_o  = (s_q.pc & mask) == mask;
        lim     = (scl == '0) ? {SCW{1'b1}} : (({1'b0, scl}) << 1) - SCW'(1);
        stick_o = tick_o && (s_q.sc >= lim);
        s_d.pc  = s_q.pc + PCW'(1);
        s_d.sc  = s_q.sc;
        if (tick_o)
            s_d.sc = (s_q.sc >= lim) ? '0 : s_q.sc + SCW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    pre_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre == '0) |-> tick_o);
    // R4
    sa_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stick_o |=> !stick_o);
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
    parameter int CW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         tick_i,
    input  logic [1:0]         en_i,
    input  logic [1:0]         pol_i,
    input  logic               cat_i,
    input  logic [1:0][CW-1:0] per_i,
    input  logic [1:0][CW-1:0] duty_i,
    output logic [1:0]         pwm_o
);
    localparam int WW = 2 * CW;

    typedef struct packed {
        logic [1:0][CW-1:0] cnt;
        logic [1:0][CW-1:0] per_sh;
        logic [1:0][CW-1:0] duty_sh;
        logic [1:0]         en_prev;
    } pr_t;

    pr_t p_d, p_q;
    logic [1:0]    run, load;
    logic [WW-1:0] cnt_w, per_w, duty_w;
    logic          act_w;

    always_comb begin
        p_d         = p_q;
        p_d.en_prev = en_i;
        load        = '0;
        run         = '0;
        pwm_o       = '0;
        cnt_w  = {p_q.cnt[0], p_q.cnt[1]};
        per_w  = {p_q.per_sh[0], p_q.per_sh[1]};
        duty_w = {p_q.duty_sh[0], p_q.duty_sh[1]};
        act_w  = cnt_w < duty_w;
        if (cat_i) begin
            run = {2{en_i[1]}};
            if (!en_i[1]) begin
                p_d.cnt = '0;
            end else if (!p_q.en_prev[1]) begin
                p_d.cnt = '0;
                load    = 2'b11;
            end else if (tick_i[1]) begin
                if ({1'b0, cnt_w} + {{WW{1'b0}}, 1'b1} >= {1'b0, per_w}) begin
                    p_d.cnt = '0;
                    load    = 2'b11;
                end else begin
                    {p_d.cnt[0], p_d.cnt[1]} = cnt_w + {{(WW-1){1'b0}}, 1'b1};
                end
            end
            pwm_o[1] = en_i[1] & (pol_i[1] ? act_w : ~act_w);
        end else begin
            for (int i = 0; i < 2; i++) begin
                run[i] = en_i[i];
                if (!en_i[i]) begin
                    p_d.cnt[i] = '0;
                end else if (!p_q.en_prev[i]) begin
                    p_d.cnt[i] = '0;
                    load[i]    = 1'b1;
                end else if (tick_i[i]) begin
                    if ({1'b0, p_q.cnt[i]} + {{CW{1'b0}}, 1'b1} >= {1'b0, p_q.per_sh[i]}) begin
                        p_d.cnt[i] = '0;
                        load[i]    = 1'b1;
                    end else begin
                        p_d.cnt[i] = p_q.cnt[i] + {{(CW-1){1'b0}}, 1'b1};
                    end
                end
                pwm_o[i] = en_i[i] & (pol_i[i] ? (p_q.cnt[i] <  p_q.duty_sh[i])
                                               : (p_q.cnt[i] >= p_q.duty_sh[i]));
            end
        end
        for (int i = 0; i < 2; i++) begin
            if (load[i]) begin
                p_d.per_sh[i]  = per_i[i];
                p_d.duty_sh[i] = duty_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R10
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load[g] |=> ($stable(p_q.per_sh[g]) && $stable(p_q.duty_sh[g])));
        // R9
        off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |=> (p_q.cnt[g] == '0));
    end

    // R11
    cat_even_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cat_i |-> !pwm_o[0]);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [NCH-1:0]    pwm_o
);
    localparam int NP = NCH / 2;

    logic [NCH-1:0]         en, pol, sel, ch_tick;
    logic [NP-1:0]          cat;
    logic [PRE_W-1:0]       pre_a, pre_b;
    logic [CW-1:0]          scl_a, scl_b;
    logic [NCH-1:0][CW-1:0] per, duty;
    logic [1:0][PRE_W-1:0]  pre_s;
    logic [1:0][CW-1:0]     scl_s;
    logic [1:0]             tk, stk;

    pwm_regfile #(.NCH(NCH), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_o(en), .pol_o(pol), .sel_o(sel), .cat_o(cat),
        .pre_a_o(pre_a), .pre_b_o(pre_b), .scl_a_o(scl_a), .scl_b_o(scl_b),
        .per_o(per), .duty_o(duty)
    );

    assign pre_s = {pre_b, pre_a};
    assign scl_s = {scl_b, scl_a};

    for (genvar s = 0; s < 2; s++) begin : g_side
        pwm_scaler #(.CW(CW)) u_scaler (
            .clk(clk), .rst_n(rst_n), .pre(pre_s[s]), .scl(scl_s[s]),
            .tick_o(tk[s]), .stick_o(stk[s])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        localparam int SIDE = (i / 2) % 2;
        assign ch_tick[i] = sel[i] ? stk[SIDE] : tk[SIDE];
    end

    for (genvar p = 0; p < NP; p++) begin : g_pair
        pwm_pair #(.CW(CW)) u_pair (
            .clk(clk), .rst_n(rst_n),
            .tick_i(ch_tick[2*p+1:2*p]), .en_i(en[2*p+1:2*p]), .pol_i(pol[2*p+1:2*p]),
            .cat_i(cat[p]), .per_i(per[2*p+1:2*p]), .duty_i(duty[2*p+1:2*p]),
            .pwm_o(pwm_o[2*p+1:2*p])
        );
    end
endmodule

// File: tb/pwm_multi_bench.sv
module pwm_multi_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pwm_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    string exp_tag_q[$];
    int    exp_hi_q[$];
    int    exp_ri_q[$];

    always #5 clk = ~clk;

    pwm_multi u_pwm_multi (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
    );

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_wave(input string tag, input int hi, input int ri);
        exp_tag_q.push_back(tag);
        exp_hi_q.push_back(hi);
        exp_ri_q.push_back(ri);
    endtask

    // monitor side: observe n transitions of one output, pop and compare
    task automatic measure(input int ch, input int n);
        int hi = 0;
        int ri = 0;
        logic prev;
        string tag;
        int e_hi, e_ri;
        @(negedge clk);
        prev = pwm_o[ch];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
            if (pwm_o[ch] && !prev) ri++;
            prev = pwm_o[ch];
        end
        tag  = exp_tag_q.pop_front();
        e_hi = exp_hi_q.pop_front();
        e_ri = exp_ri_q.pop_front();
        check({tag, " high count"}, hi, e_hi);
        check({tag, " rising edges"}, ri, e_ri);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int low_cnt;
        logic prev, cur;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset outputs", pwm_o, 0);

        // R1 map: periods 0x10+i, duties 0x18+i
        wr(6'h10, 8'd10); wr(6'h18, 8'd3);
        wr(6'h11, 8'd10); wr(6'h19, 8'd3);
        wr(6'h12, 8'd8);  wr(6'h1A, 8'd9);
        wr(6'h13, 8'd10); wr(6'h1B, 8'd3);
        wr(6'h16, 8'd8);  wr(6'h1E, 8'd0);
        wr(6'h17, 8'd10); wr(6'h1F, 8'd3);
        wr(6'h01, 8'hCD);
        wr(6'h00, 8'hCF);
        repeat (50) @(negedge clk);

        expect_wave("R6 ch0 pol1 10/3", 30, 10);  measure(0, 100);
        expect_wave("R7 ch1 pol0 10/3", 70, 10);  measure(1, 100);
        expect_wave("R8 ch2 duty>=period", 80, 0); measure(2, 80);
        expect_wave("R8 ch6 duty zero", 0, 0);    measure(6, 80);

        // R3: A divided by 4, B left at 1
        wr(6'h04, 8'h02);
        repeat (100) @(negedge clk);
        expect_wave("R3 ch0 prescale 4", 48, 4);  measure(0, 160);
        expect_wave("R5 ch7 B side unaffected", 30, 10); measure(7, 100);

        // R4/R5: scaled clock on ch0, SA = A/(2*2)
        wr(6'h04, 8'h00);
        wr(6'h05, 8'd2);
        wr(6'h02, 8'h01);
        wr(6'h10, 8'd5); wr(6'h18, 8'd2);
        repeat (100) @(negedge clk);
        expect_wave("R4 ch0 scaled 5/2", 32, 4);  measure(0, 80);
        expect_wave("R5 ch1 plain A", 70, 10);    measure(1, 100);

        // R4: scale 0 counts as 256
        wr(6'h05, 8'd0);
        wr(6'h10, 8'd2); wr(6'h18, 8'd1);
        repeat (1100) @(negedge clk);
        expect_wave("R4 ch0 scale zero", 1024, 2); measure(0, 2048);

        // R9: disable ch0 and ch1
        wr(6'h00, 8'hCC);
        low_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!pwm_o[0] && !pwm_o[1]) low_cnt++;
        end
        check("R9 disabled outputs low", low_cnt, 20);

        // R11: join pair 0, 16-bit period 300, duty 100
        wr(6'h10, 8'h01); wr(6'h11, 8'h2C);
        wr(6'h18, 8'h00); wr(6'h19, 8'h64);
        wr(6'h01, 8'hCE);
        wr(6'h03, 8'h01);
        wr(6'h00, 8'hCE);
        repeat (700) @(negedge clk);
        expect_wave("R11 joined pair on ch1", 200, 2); measure(1, 600);
        check("R11 even output low", pwm_o[0], 0);

        // R10: duty write mid-period on ch3 must wait for the wrap
        prev = pwm_o[3];
        forever begin
            @(negedge clk);
            cur = pwm_o[3];
            if (cur && !prev) break;
            prev = cur;
        end
        repeat (3) @(negedge clk);
        wr(6'h1B, 8'd7);
        @(negedge clk);
        check("R10 no change before wrap", pwm_o[3], 0);
        repeat (20) @(negedge clk);
        expect_wave("R10 new duty after wrap", 70, 10); measure(3, 100);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule